// File: doc/BRIEF.md
# Clock Alarm Edge-Capture Interrupt Register

This block watches the four alarm levels produced by a telecom clock synchronizer: loss of the primary reference, loss of the secondary reference, the PLL entering holdover, and the PLL losing lock. Every level is brought into the local clock domain through a flop chain. Each change of level is then recorded as its own sticky event bit, with one bit for the rising transition and one for the falling transition. The event bits are held until software reads them over a byte-wide read bus. That read returns the pending events and clears them.

A status register gives the live, synchronized level of every alarm. An identification register tells software which interrupt line the block is wired to. A single interrupt output stays high for as long as any event bit is pending. Software takes the interrupt, reads the event register once, and in that way learns every transition since its previous read.

Top module: `clk_alarm_evt`

## Requirements
- R1: After reset the event register is 0x00, irq_o is low and rd_data_o is 0x00.
- R2: Alarm index i is one of: 0 = primary lost, 1 = secondary lost, 2 = holdover, 3 = unlock. A 0-to-1 change of alarm i sets event bit 2i. A 1-to-0 change sets event bit 2i+1.
- R3: A read of address 0 (the event register) returns all pending event bits in rd_data_o on the cycle after the read strobe and clears them. A second read with no new transitions returns 0x00.
- R4: irq_o is high whenever at least one event bit is pending. It goes low on the cycle after a clearing read, provided no transition lands in that read cycle.
- R5: A transition detected in the same cycle as a clearing read is left set after the read. The read itself returns only the bits that were pending before it.
- R6: If an alarm rises and later falls between two reads, both its rise bit and its fall bit are set.
- R7: A read of address 1 (status) returns the synchronized alarm levels in the upper nibble, with unlock at bit 4, holdover at bit 5, secondary lost at bit 6 and primary lost at bit 7. The lower nibble reads zero. This read clears no event.
- R8: A read of address 2 returns the IRQ_LINE parameter in bits 3:0 and zero in bits 7:4, where 0xF means the function is absent. This read clears no event.
- R9: With SYNC_STAGES = 2, an alarm change that is set up before a rising clock edge raises irq_o after the third rising edge, counting that edge as the first.
- R10: After reset, no event is logged for alarm levels that were already present when reset was released.
- R11: A read of address 3 returns 0x00 and clears no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alarm_i | input | 4 | Asynchronous alarm levels, indexed as in R2 |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | 2 | Register select: 0 event, 1 status, 2 identification, 3 reserved |
| rd_data_o | output | 8 | Read data, registered and valid the cycle after the strobe |
| irq_o | output | 1 | High while any event bit is pending |

## Verification
The clearing read and the capture of a new transition can fall on the same clock edge. That is the case where an event could be lost. The bench sets one event pending and then changes a second alarm. It times the clearing read so that the read strobe sits in the exact cycle in which the synchronized edge is detected. The check then requires two things: the read returns only the earlier bit, and irq_o stays high until a second read returns the new bit.

// File: rtl/clk_alarm_pkg.sv
package clk_alarm_pkg;
  localparam int NUM_ALARM = 4;
  localparam int EVT_W     = 2 * NUM_ALARM;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_EVT = 2'd0,
    REG_STS = 2'd1,
    REG_ID  = 2'd2,
    REG_RSV = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/alarm_edge.sv
module alarm_edge #(
  parameter int N   = 4,
  parameter int LAT = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   lvl_i,
  input  logic           clr_i,
  output logic [2*N-1:0] evt_o,
  output logic [2*N-1:0] new_o,
  output logic           warm_o
);
  logic [N-1:0]   hist_q;
  logic [LAT-1:0] vld_q;
  logic [2*N-1:0] evt_q;

  // history is valid once the sync chain and hist_q both hold real samples
  assign warm_o = vld_q[LAT-1];

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign new_o[2*i]   = warm_o &  lvl_i[i] & ~hist_q[i];
    assign new_o[2*i+1] = warm_o & ~lvl_i[i] &  hist_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      vld_q  <= '0;
      evt_q  <= '0;
    end else begin
      hist_q <= lvl_i;
      vld_q  <= {vld_q[LAT-2:0], 1'b1};
      evt_q  <= (clr_i ? '0 : evt_q) | new_o;
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import clk_alarm_pkg::*;
#(
  parameter logic [3:0] IRQ_LINE = 4'h5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [NUM_ALARM-1:0] lvl_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] sts;
  logic [DATA_W-1:0] rd_q;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(rd_addr_i);
  assign clr_o = rd_en_i && (sel == REG_EVT);

  // live levels packed from the top bit down
  assign sts[DATA_W-NUM_ALARM-1:0] = '0;
  for (genvar i = 0; i < NUM_ALARM; i++) begin : g_sts
    assign sts[DATA_W-1-i] = lvl_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (rd_en_i) begin
      unique case (sel)
        REG_EVT: rd_q <= evt_i;
        REG_STS: rd_q <= sts;
        REG_ID:  rd_q <= {4'h0, IRQ_LINE};
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/clk_alarm_evt.sv
module clk_alarm_evt
  import clk_alarm_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] IRQ_LINE    = 4'h5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_ALARM-1:0] alarm_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int EDGE_LAT = SYNC_STAGES + 1;

  logic [NUM_ALARM-1:0] lvl;
  logic [EVT_W-1:0]     evt_q;
  logic [EVT_W-1:0]     evt_new;
  logic                 warm;
  logic                 clr;

  alarm_sync #(.W(NUM_ALARM), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (alarm_i),
    .q_o   (lvl)
  );

  alarm_edge #(.N(NUM_ALARM), .LAT(EDGE_LAT)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .clr_i (clr),
    .evt_o (evt_q),
    .new_o (evt_new),
    .warm_o(warm)
  );

  alarm_regs #(.IRQ_LINE(IRQ_LINE)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .rd_addr_i(rd_addr_i),
    .evt_i    (evt_q),
    .lvl_i    (lvl),
    .clr_o    (clr),
    .rd_data_o(rd_data_o)
  );

  assign irq_o = |evt_q;
endmodule

// File: rtl/clk_alarm_evt_chk.sv
module clk_alarm_evt_chk
  import clk_alarm_pkg::*;
#(
  parameter logic [3:0] IRQ_LINE = 4'h5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_o,
  input logic [EVT_W-1:0]  evt_q,
  input logic [EVT_W-1:0]  evt_new,
  input logic              warm
);
  logic rd_clr;
  assign rd_clr = rd_en_i && (rd_addr_i == 2'd0);

  AST_READ_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr |=> (rd_data_o == $past(evt_q))); // R3
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R3
  AST_KEEP_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr |=> (evt_q == $past(evt_new))); // R5
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr && (evt_new == '0)) |=> !irq_o); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(evt_new) != '0)); // R4
  AST_ID_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == 2'd2) |=> (rd_data_o == {4'h0, IRQ_LINE})); // R8
  AST_NO_CLR_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i != 2'd0 && evt_new == '0) |=> (evt_q == $past(evt_q))); // R7
  AST_WARM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !warm |-> (evt_q == '0 && !irq_o)); // R10
endmodule

bind clk_alarm_evt clk_alarm_evt_chk #(.IRQ_LINE(IRQ_LINE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_en_i  (rd_en_i),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o),
  .irq_o    (irq_o),
  .evt_q    (evt_q),
  .evt_new  (evt_new),
  .warm     (warm)
);

// File: tb/clk_alarm_evt_bench.sv
module clk_alarm_evt_bench;
  localparam int         CLK_PERIOD = 10;
  localparam logic [3:0] ID_VAL     = 4'h9;
  localparam int         NVEC       = 9;
  localparam int         WD_CYCLES  = 20000;

  // {alarm level, expected events after change}
  localparam logic [11:0] VEC [NVEC] = '{
    {4'b0001, 8'h01}, {4'b0011, 8'h04}, {4'b0010, 8'h02},
    {4'b1010, 8'h40}, {4'b1110, 8'h10}, {4'b0100, 8'h88},
    {4'b0000, 8'h20}, {4'b1111, 8'h55}, {4'b0000, 8'hAA}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] alarm = 4'h0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_alarm_evt #(.SYNC_STAGES(2), .IRQ_LINE(ID_VAL)) u_clk_alarm_evt (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .alarm_i  (alarm),
    .rd_en_i  (rd_en),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .irq_o    (irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] sts_of(input logic [3:0] a);
    return {a[0], a[1], a[2], a[3], 4'h0};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WD_CYCLES, WD_CYCLES);
    finish_run();
  end

  initial begin
    logic [7:0] d;
    wait_cyc(3);
    check("R1 rd_data reset", rd_data, 8'h00);
    check("R1 irq reset", {7'h0, irq}, 8'h00);
    rst_n = 1'b1;
    wait_cyc(5);
    rd(2'd0, d);
    check("R1 event after reset", d, 8'h00);

    // table walk: R2 layout, R3 clear, R4 irq drop, R7 status
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      alarm = VEC[k][11:8];
      wait_cyc(6);
      check("R4 irq pending", {7'h0, irq}, 8'h01);
      rd(2'd1, d);
      check("R7 status levels", d, sts_of(VEC[k][11:8]));
      rd(2'd0, d);
      check("R2 event layout", d, VEC[k][7:0]);
      check("R4 irq low after read", {7'h0, irq}, 8'h00);
      rd(2'd0, d);
      check("R3 second read zero", d, 8'h00);
    end

    // R9 latency: irq after third rising edge
    @(negedge clk);
    alarm = 4'b0001;
    @(negedge clk);
    check("R9 irq after edge 1", {7'h0, irq}, 8'h00);
    @(negedge clk);
    check("R9 irq after edge 2", {7'h0, irq}, 8'h00);
    @(negedge clk);
    check("R9 irq after edge 3", {7'h0, irq}, 8'h01);
    rd(2'd0, d);
    check("R9 event", d, 8'h01);

    // R5: transition lands in the clearing-read cycle
    @(negedge clk);
    alarm = 4'b0011;
    wait_cyc(5);
    @(negedge clk);
    alarm = 4'b0111;       // before edge A
    @(negedge clk);        // after edge A: s1 updated
    @(negedge clk);        // after edge B: edge detected now
    rd_en = 1'b1;
    rd_addr = 2'd0;
    @(negedge clk);        // after edge C: clear + capture
    rd_en = 1'b0;
    check("R5 read returns old only", rd_data, 8'h04);
    check("R5 irq stays high", {7'h0, irq}, 8'h01);
    rd(2'd0, d);
    check("R5 new event kept", d, 8'h10);

    // R6: rise then fall between reads
    @(negedge clk);
    alarm = 4'b1111;
    wait_cyc(4);
    alarm = 4'b0111;
    wait_cyc(6);
    rd(2'd0, d);
    check("R6 rise and fall both set", d, 8'hC0);

    // R7/R8/R11: non-event reads clear nothing
    @(negedge clk);
    alarm = 4'b0110;
    wait_cyc(6);
    rd(2'd1, d);
    check("R7 status", d, sts_of(4'b0110));
    rd(2'd2, d);
    check("R8 id register", d, {4'h0, ID_VAL});
    rd(2'd3, d);
    check("R11 reserved reads zero", d, 8'h00);
    check("R7 irq still pending", {7'h0, irq}, 8'h01);
    rd(2'd0, d);
    check("R8 R11 event kept", d, 8'h02);

    // R10: levels present at reset release log nothing
    @(negedge clk);
    rst_n = 1'b0;
    alarm = 4'b1111;
    wait_cyc(3);
    check("R1 irq in reset", {7'h0, irq}, 8'h00);
    rst_n = 1'b1;
    wait_cyc(8);
    check("R10 irq quiet", {7'h0, irq}, 8'h00);
    rd(2'd0, d);
    check("R10 no spurious event", d, 8'h00);
    rd(2'd1, d);
    check("R10 status live", d, 8'hF0);

    finish_run();
  end
endmodule